// File: doc/BRIEF.md
# Tamper Input Glitch Filter

This block watches one external tamper pin and decides when a genuine tamper event has happened. The raw pin is brought into the system clock domain through a two-stage synchronizer. A polarity control then maps it to an internal "active" level. When filtering is on, the active level must hold across a programmed number of consecutive samples before the event is accepted. Samples are taken on one of eight rate strobes, picked by a 3-bit select field. A duration of zero turns the filter off, so the first active system-clock sample is accepted.

An accepted event sets a sticky status flag. The flag stays set until an explicit clear. The interrupt request is the status flag gated by an interrupt enable. The status flag comes out of reset set, so software has to clear it once after power-up. The rate strobes come from an external prescaler, and event logging is handled elsewhere. Several copies of the block sit side by side, one per tamper input, and each copy has its own enable and its own status.

Top module: `tamper_glitch_filter`

## Requirements
- R1: After reset is released, `status_o` is 1. With `irq_en_i` at 1, `irq_o` is also 1.
- R2: When `pol_i` is 0, the pin is active when high. When `pol_i` is 1, the pin is active when low.
- R3: When `dur_i` is nonzero, `status_o` rises on the clock edge that samples the `dur_i`-th consecutive selected strobe seen with the synchronized pin active. It stays 0 for all earlier strobes.
- R4: A selected strobe that samples the synchronized pin inactive resets the count to zero. A later event then needs a full `dur_i` active strobes.
- R5: Only `tick_i[sel_i]` is counted. Pulses on the other strobe bits have no effect. The bit-to-rate map is: 0 = 32 kHz, 1 = 512 Hz, 2 = 128 Hz, 3 = 64 Hz, 4 = 16 Hz, 5 = 8 Hz, 6 = 4 Hz, 7 = 2 Hz.
- R6: When `dur_i` is 0, filtering is bypassed. The pin passes through two synchronizer flops, and `status_o` rises on the third clock edge after the pin becomes active.
- R7: `status_o` is sticky and can only be lowered by `clr_i`. If `clr_i` and a new event fall in the same cycle, the clear wins. After a clear with the pin still active, a new filtered event needs a fresh count of `dur_i` strobes.
- R8: While `en_i` is 0, the count is held at zero and `status_o` cannot be set. After `en_i` returns to 1, a full count is needed.
- R9: `irq_o` is 1 exactly when `status_o` and `irq_en_i` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Raw tamper pin, asynchronous to the clock |
| en_i | input | 1 | Detection enable for this input |
| pol_i | input | 1 | Active level select (0 high, 1 low) |
| dur_i | input | 4 | Number of consecutive active samples required (0 bypasses the filter) |
| sel_i | input | 3 | Selects which bit of `tick_i` is the sample strobe |
| tick_i | input | 8 | Single-cycle rate strobes from the prescaler |
| clr_i | input | 1 | Status clear pulse |
| irq_en_i | input | 1 | Interrupt enable |
| status_o | output | 1 | Sticky tamper status |
| irq_o | output | 1 | Interrupt request |

## Verification
The main function is swept over every polarity, every strobe select and every nonzero duration. In each run, pulses on all the unselected strobe bits are interleaved with the selected strobe. A status that rises one strobe early or late exposes an off-by-one in the count. A rise during an interleaved pulse exposes a wrong strobe decode.

Directed patterns then cover the remaining behaviour:
- A pin that drops for one sample in mid-count, which separates a count that resets from one that only pauses.
- A clear while the pin is held active, in both filtered and bypass mode, which checks clear priority and the need for a fresh count.
- A long run of strobes with the enable low.
- The exact edge count through the synchronizer in bypass mode.

// File: rtl/tamper_pkg.sv
package tamper_pkg;
  localparam int unsigned DUR_W  = 4;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned N_TAPS = 1 << SEL_W;

  typedef enum logic [SEL_W-1:0] {
    RATE_32K = 3'd0,
    RATE_512 = 3'd1,
    RATE_128 = 3'd2,
    RATE_64  = 3'd3,
    RATE_16  = 3'd4,
    RATE_8   = 3'd5,
    RATE_4   = 3'd6,
    RATE_2   = 3'd7
  } rate_sel_e;
endpackage

// File: rtl/tamper_sync.sv
module tamper_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], d_i};
  end

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/tamper_tick_sel.sv
module tamper_tick_sel #(
  parameter int unsigned SEL_W  = 3,
  localparam int unsigned N_TAPS = 1 << SEL_W
) (
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [N_TAPS-1:0] tick_i,
  output logic              sample_o
);
  logic [N_TAPS-1:0] hit;

  for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
    assign hit[g] = tick_i[g] && (sel_i == SEL_W'(g));
  end

  assign sample_o = |hit;
endmodule

// File: rtl/tamper_persist.sv
module tamper_persist #(
  parameter int unsigned DUR_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             active_i,
  input  logic             sample_i,
  input  logic [DUR_W-1:0] dur_i,
  input  logic             restart_i,
  output logic             hit_o,
  output logic [DUR_W-1:0] cnt_o
);
  logic [DUR_W-1:0] cnt_q;
  logic [DUR_W:0]   cnt_inc;
  logic             bypass;
  logic             reached;

  always_comb begin
    bypass  = (dur_i == '0);
    cnt_inc = {1'b0, cnt_q} + 1'b1;
    reached = (cnt_inc >= {1'b0, dur_i});
    if (!en_i)       hit_o = 1'b0;
    else if (bypass) hit_o = active_i;
    else             hit_o = sample_i && active_i && reached;
  end

  // count saturates at the threshold; restart forces a fresh run
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!en_i || bypass || restart_i) begin
      cnt_q <= '0;
    end else if (sample_i) begin
      if (!active_i)    cnt_q <= '0;
      else if (!reached) cnt_q <= cnt_inc[DUR_W-1:0];
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tamper_glitch_filter.sv
module tamper_glitch_filter
  import tamper_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_i,
  input  logic              en_i,
  input  logic              pol_i,
  input  logic [DUR_W-1:0]  dur_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [N_TAPS-1:0] tick_i,
  input  logic              clr_i,
  input  logic              irq_en_i,
  output logic              status_o,
  output logic              irq_o
);
  logic             pin_sync;
  logic             active;
  logic             sample;
  logic             hit;
  logic [DUR_W-1:0] cnt;
  logic             status_q;

  tamper_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  assign active = pin_sync ^ pol_i;

  tamper_tick_sel #(.SEL_W(SEL_W)) u_tick_sel (
    .sel_i   (sel_i),
    .tick_i  (tick_i),
    .sample_o(sample)
  );

  tamper_persist #(.DUR_W(DUR_W)) u_persist (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .active_i (active),
    .sample_i (sample),
    .dur_i    (dur_i),
    .restart_i(clr_i),
    .hit_o    (hit),
    .cnt_o    (cnt)
  );

  // sticky flag, set out of reset, clear has priority
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   status_q <= 1'b1;
    else if (clr_i) status_q <= 1'b0;
    else if (hit)   status_q <= 1'b1;
  end

  assign status_o = status_q;
  assign irq_o    = status_q & irq_en_i;
endmodule

// File: rtl/tamper_glitch_filter_chk.sv
module tamper_glitch_filter_chk
  import tamper_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic [DUR_W-1:0]  dur_i,
  input logic [SEL_W-1:0]  sel_i,
  input logic [N_TAPS-1:0] tick_i,
  input logic              clr_i,
  input logic              irq_en_i,
  input logic              status_o,
  input logic              irq_o,
  input logic [DUR_W-1:0]  cnt
);
  assert_clear_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !status_o);

  assert_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o && !clr_i) |=> status_o);

  assert_disabled_no_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !status_o) |=> !status_o);

  assert_disabled_cnt_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt == '0));

  assert_set_needs_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && dur_i != '0 && !status_o && !tick_i[sel_i]) |=> !status_o);

  assert_irq_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |-> !irq_o);

  assert_irq_needs_status_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o |-> !irq_o);
endmodule

bind tamper_glitch_filter tamper_glitch_filter_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .dur_i   (dur_i),
  .sel_i   (sel_i),
  .tick_i  (tick_i),
  .clr_i   (clr_i),
  .irq_en_i(irq_en_i),
  .status_o(status_o),
  .irq_o   (irq_o),
  .cnt     (cnt)
);

// File: tb/tb_tamper_glitch_filter.sv
`timescale 1ns/1ps
module tb_tamper_glitch_filter;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pin_i = 1'b0;
  logic       en_i = 1'b1;
  logic       pol_i = 1'b0;
  logic [3:0] dur_i = 4'd0;
  logic [2:0] sel_i = 3'd0;
  logic [7:0] tick_i = 8'h00;
  logic       clr_i = 1'b0;
  logic       irq_en_i = 1'b1;
  logic       status_o;
  logic       irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;

  tamper_glitch_filter dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i), .en_i(en_i), .pol_i(pol_i),
    .dur_i(dur_i), .sel_i(sel_i), .tick_i(tick_i), .clr_i(clr_i),
    .irq_en_i(irq_en_i), .status_o(status_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic set_pin(input logic act_lvl);
    pin_i = act_lvl ^ pol_i;
    step(3);
  endtask

  task automatic pulse(input logic [7:0] v);
    tick_i = v;
    step(1);
    tick_i = 8'h00;
  endtask

  task automatic clear();
    clr_i = 1'b1;
    step(1);
    clr_i = 1'b0;
  endtask

  // count dur strobes; others interleaved must not count
  task automatic run_count(input int d, input string req);
    for (int k = 1; k <= d; k++) begin
      pulse(~(8'h01 << sel_i));
      chk({req, " unselected strobe"}, status_o, 1'b0);
      pulse(8'h01 << sel_i);
      chk(req, status_o, (k == d) ? 1'b1 : 1'b0);
    end
  endtask

  initial begin
    step(2);
    rst_ni = 1'b1;
    step(1);
    chk("R1 status after reset", status_o, 1'b1);
    chk("R1 irq after reset", irq_o, 1'b1);

    irq_en_i = 1'b0;
    step(1);
    chk("R9 irq gated off", irq_o, 1'b0);
    irq_en_i = 1'b1;
    step(1);
    chk("R9 irq on", irq_o, 1'b1);
    clear();
    chk("R7 clear", status_o, 1'b0);
    chk("R9 irq low after clear", irq_o, 1'b0);

    // sweep polarity x select x duration (R2, R3, R5)
    for (int p = 0; p < 2; p++) begin
      for (int s = 0; s < 8; s++) begin
        for (int d = 1; d < 16; d++) begin
          pol_i = p[0];
          sel_i = s[2:0];
          dur_i = d[3:0];
          set_pin(1'b0);
          pulse(8'hFF);
          clear();
          chk("R2 idle level", status_o, 1'b0);
          set_pin(1'b1);
          run_count(d, p ? "R2 R3 R5 active low" : "R3 R5 active high");
        end
      end
    end

    // R4: dropout in mid count
    pol_i = 1'b0; sel_i = 3'd3; dur_i = 4'd4;
    set_pin(1'b0); pulse(8'hFF); clear();
    set_pin(1'b1);
    for (int k = 0; k < 3; k++) pulse(8'h08);
    chk("R4 before dropout", status_o, 1'b0);
    set_pin(1'b0);
    pulse(8'h08);
    set_pin(1'b1);
    for (int k = 0; k < 3; k++) pulse(8'h08);
    chk("R4 count restarted", status_o, 1'b0);
    pulse(8'h08);
    chk("R4 full count", status_o, 1'b1);

    // R7: clear while held active, filtered
    clear();
    chk("R7 cleared while active", status_o, 1'b0);
    run_count(4, "R7 fresh count");
    // clear and hit in the same cycle
    clear();
    for (int k = 0; k < 3; k++) pulse(8'h08);
    tick_i = 8'h08; clr_i = 1'b1;
    step(1);
    tick_i = 8'h00; clr_i = 1'b0;
    chk("R7 clear beats hit", status_o, 1'b0);

    // R8: disabled input
    clear();
    en_i = 1'b0;
    for (int k = 0; k < 20; k++) pulse(8'h08);
    chk("R8 disabled no status", status_o, 1'b0);
    en_i = 1'b1;
    run_count(4, "R8 full count after enable");

    // R6: bypass
    dur_i = 4'd0;
    set_pin(1'b0);
    clear();
    step(2);
    chk("R6 bypass idle", status_o, 1'b0);
    pin_i = 1'b1;
    step(2);
    chk("R6 after two edges", status_o, 1'b0);
    step(1);
    chk("R6 on third edge", status_o, 1'b1);
    clear();
    chk("R7 bypass clear", status_o, 1'b0);
    step(1);
    chk("R7 bypass re-set", status_o, 1'b1);
    pol_i = 1'b1;
    set_pin(1'b0);
    clear();
    step(3);
    chk("R2 R6 bypass inactive low pol", status_o, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule